// File: doc/BRIEF.md
# Resumable Byte Block Copier

This block moves a run of bytes from one address range to another over a single-port memory bus. A start pulse loads a source pointer, a destination pointer and a 16-bit byte count. The engine then issues two priming reads, first at the source address and then at the destination address, and after that moves one byte per read-then-write pair. The write carries the data returned by the read just before it.

Two run modes exist. In the resumable mode, a pending interrupt request stops the copy at a byte boundary. The live pointer and count outputs then describe exactly the work still to do, so a wrapper can start the engine again from those values. In the atomic mode, no request of any kind stops the run.

The memory bus uses a one-cycle strobe made of request, write enable, address and write data. Read data is valid in the cycle after a read request.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, busy, done and suspended are 0 and no memory request is issued.
- R2: In the two cycles after a start is accepted in idle, the engine reads at the source address and then at the destination address, one access per cycle.
- R3: For byte i (counting from 0), the engine reads address src+i and in the next cycle writes the returned data to dst+i. Bytes go in ascending order with no idle cycles, so a full run of n bytes issues exactly 2(n+1) accesses in 2(n+1) busy cycles.
- R4: A count of 0 issues only the two priming reads and then finishes with the pointers unchanged and the count at 0.
- R5: In the cycle after the last access of a complete run, busy is 0, done is 1, srcPtr is src+n, dstPtr is dst+n and count is 0. Done and suspended each stay at their value until the next start is accepted.
- R6: The mode input is sampled when a start is accepted: 0 selects the resumable mode and 1 selects the atomic mode. In the resumable mode, a request counts as pending when nmiReq is 1, or when irqReq is 1 and irqMask is 0. A pending request is sampled only in the write cycle of a byte. If bytes remain after that write, the run stops: busy is 0, suspended is 1, and the outputs hold src+k, dst+k and n−k, where k is the number of bytes moved.
- R7: Requests raised during priming reads or byte read cycles, and maskable requests while irqMask is 1, do not change the access sequence.
- R8: In the atomic mode, neither irqReq nor nmiReq ever stops the run, and it always ends with done.
- R9: A pending request in the write cycle of the final byte ends the run with done, not suspended.
- R10: A start pulse while busy is ignored, and the running copy continues unchanged.
- R11: Repeatedly restarting from the output pointers and count after each suspension leaves memory the same as one uninterrupted forward copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| modeAtomic | input | 1 | 1 = atomic mode, 0 = resumable mode |
| srcIn | input | AW | Source start address |
| dstIn | input | AW | Destination start address |
| cntIn | input | CW | Number of bytes to copy |
| irqReq | input | 1 | Maskable interrupt request |
| irqMask | input | 1 | 1 masks irqReq |
| nmiReq | input | 1 | Non-maskable interrupt request |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | 1 = write access |
| memAddr | output | AW | Access address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed all bytes |
| suspended | output | 1 | Last run stopped early on a request |
| srcPtr | output | AW | Next source address |
| dstPtr | output | AW | Next destination address |
| count | output | CW | Bytes still to move |

## Verification
The hardest case to reach from the ports is a request that is pending exactly in the write cycle of the final byte, because it has to be told apart from a request that suspends the run one byte earlier. The bench holds a non-maskable request high for a whole resumable run, so every byte boundary sees it. The run then advances one byte per restart until the last byte, which must end with done. Other runs hold a masked request or a non-maskable request in atomic mode for the whole run. They also randomise requests and stray start pulses on every cycle, and a behavioural model of the access sequence is compared against the bus on each clock.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME_SRC,
    ST_PRIME_DST,
    ST_COPY_RD,
    ST_COPY_WR
  } copyState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // capture start values
    logic advance;  // step pointers and count after a byte write
    logic memReq;
    logic memWe;
    logic selDst;   // address from destination pointer
  } dpCtl_t;

endpackage

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   modeAtomic,
  input  logic   irqReq,
  input  logic   irqMask,
  input  logic   nmiReq,
  input  logic   cntZero,
  input  logic   cntOne,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done,
  output logic   suspended,
  output logic   runAtomic
);

  copyState_t st, stNext;
  logic finishNow, suspendNow, pending;

  assign pending = nmiReq | (irqReq & ~irqMask);
  assign busy    = (st != ST_IDLE);

  always_comb begin
    ctl        = '0;
    stNext     = st;
    finishNow  = 1'b0;
    suspendNow = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stNext   = ST_PRIME_SRC;
        end
      end
      ST_PRIME_SRC: begin
        ctl.memReq = 1'b1;
        stNext     = ST_PRIME_DST;
      end
      ST_PRIME_DST: begin
        ctl.memReq = 1'b1;
        ctl.selDst = 1'b1;
        if (cntZero) begin
          finishNow = 1'b1;
          stNext    = ST_IDLE;
        end else begin
          stNext = ST_COPY_RD;
        end
      end
      ST_COPY_RD: begin
        ctl.memReq = 1'b1;
        stNext     = ST_COPY_WR;
      end
      ST_COPY_WR: begin
        ctl.memReq  = 1'b1;
        ctl.memWe   = 1'b1;
        ctl.selDst  = 1'b1;
        ctl.advance = 1'b1;
        if (cntOne) begin
          finishNow = 1'b1;
          stNext    = ST_IDLE;
        end else if (!runAtomic && pending) begin
          suspendNow = 1'b1;
          stNext     = ST_IDLE;
        end else begin
          stNext = ST_COPY_RD;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      suspended <= 1'b0;
      runAtomic <= 1'b0;
    end else begin
      st <= stNext;
      if (ctl.load) begin
        runAtomic <= modeAtomic;
        done      <= 1'b0;
        suspended <= 1'b0;
      end
      if (finishNow)  done      <= 1'b1;
      if (suspendNow) suspended <= 1'b1;
    end
  end

endmodule

// File: rtl/blkcopy_dp.sv
module blkcopy_dp
  import blkcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] srcIn,
  input  logic [AW-1:0] dstIn,
  input  logic [CW-1:0] cntIn,
  input  logic [7:0]    memRdata,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  output logic [AW-1:0] srcPtr,
  output logic [AW-1:0] dstPtr,
  output logic [CW-1:0] count,
  output logic          cntZero,
  output logic          cntOne
);

  localparam logic [AW-1:0] PTR_STEP = AW'(1);
  localparam logic [CW-1:0] CNT_STEP = CW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
      count  <= '0;
    end else if (ctl.load) begin
      srcPtr <= srcIn;
      dstPtr <= dstIn;
      count  <= cntIn;
    end else if (ctl.advance) begin
      srcPtr <= srcPtr + PTR_STEP;
      dstPtr <= dstPtr + PTR_STEP;
      count  <= count - CNT_STEP;
    end
  end

  assign memAddr  = ctl.selDst ? dstPtr : srcPtr;
  // read data of the previous cycle goes straight out on the write
  assign memWdata = memRdata;
  assign cntZero  = (count == '0);
  assign cntOne   = (count == CNT_STEP);

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          modeAtomic,
  input  logic [AW-1:0] srcIn,
  input  logic [AW-1:0] dstIn,
  input  logic [CW-1:0] cntIn,
  input  logic          irqReq,
  input  logic          irqMask,
  input  logic          nmiReq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  input  logic [7:0]    memRdata,
  output logic          busy,
  output logic          done,
  output logic          suspended,
  output logic [AW-1:0] srcPtr,
  output logic [AW-1:0] dstPtr,
  output logic [CW-1:0] count
);

  dpCtl_t ctl;
  logic   cntZero, cntOne, runAtomic;

  blkcopy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeAtomic(modeAtomic),
    .irqReq(irqReq), .irqMask(irqMask), .nmiReq(nmiReq),
    .cntZero(cntZero), .cntOne(cntOne), .ctl(ctl),
    .busy(busy), .done(done), .suspended(suspended), .runAtomic(runAtomic)
  );

  blkcopy_dp #(.AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .srcIn(srcIn), .dstIn(dstIn), .cntIn(cntIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .srcPtr(srcPtr), .dstPtr(dstPtr), .count(count),
    .cntZero(cntZero), .cntOne(cntOne)
  );

  assign memReq = ctl.memReq;
  assign memWe  = ctl.memWe;

endmodule

// File: rtl/blkcopy_checker.sv
module blkcopy_checker #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          done,
  input logic          suspended,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] srcPtr,
  input logic [AW-1:0] dstPtr,
  input logic [CW-1:0] count,
  input logic          runAtomic
);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq) else $error("R1 request while idle");

  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> $past(memReq && !memWe)) else $error("R3 write without read");

  a_r3_pointer_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (count != $past(count))) |->
      ((count == $past(count) - CW'(1)) && (srcPtr == $past(srcPtr) + AW'(1))
       && (dstPtr == $past(dstPtr) + AW'(1)))) else $error("R3 bad step");

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && suspended)) else $error("R5 done and suspended together");

  a_r6_suspend_has_work: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> (count != '0)) else $error("R6 suspended with zero count");

  a_r8_atomic_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && runAtomic) |-> done) else $error("R8 atomic run not done");

endmodule

bind blkcopy_engine blkcopy_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .suspended(suspended),
  .memReq(memReq), .memWe(memWe), .srcPtr(srcPtr), .dstPtr(dstPtr),
  .count(count), .runAtomic(runAtomic)
);

// File: tb/blkcopy_engine_test.sv
module blkcopy_engine_test;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int MEMN = 1024;

  logic clk = 0;
  logic rstN = 0;
  logic start = 0, modeAtomic = 0, irqReq = 0, irqMask = 0, nmiReq = 0;
  logic [AW-1:0] srcIn = '0, dstIn = '0;
  logic [CW-1:0] cntIn = '0;
  logic memReq, memWe, busy, done, suspended;
  logic [AW-1:0] memAddr, srcPtr, dstPtr;
  logic [7:0] memWdata, memRdata;
  logic [CW-1:0] count;

  logic [7:0] mem [MEMN];
  logic [7:0] refMem [MEMN];

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blkcopy_engine #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .modeAtomic(modeAtomic),
    .srcIn(srcIn), .dstIn(dstIn), .cntIn(cntIn),
    .irqReq(irqReq), .irqMask(irqMask), .nmiReq(nmiReq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .suspended(suspended),
    .srcPtr(srcPtr), .dstPtr(dstPtr), .count(count)
  );

  // bus memory: read data one cycle after request
  always @(posedge clk) begin
    if (memReq && !memWe) memRdata <= mem[memAddr % MEMN];
    if (memReq && memWe) mem[memAddr % MEMN] <= memWdata;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct { int addr; bit we; } acc_t;

  // irqStyle: 0 quiet, 1 random, 2 nmi held, 3 masked irq held
  task automatic runCopy(input int s, input int d, input int n, input bit atomic,
                         input int irqStyle, output bit wasSusp);
    acc_t q[$];
    int k = 0;
    bit stopNext = 0;
    bit nmiV, irqV, mskV, pend;
    q.push_back('{s, 0});
    q.push_back('{d, 0});
    for (int i = 0; i < n; i++) begin
      q.push_back('{s + i, 0});
      q.push_back('{d + i, 1});
    end
    @(negedge clk);
    start = 1; modeAtomic = atomic;
    srcIn = AW'(s); dstIn = AW'(d); cntIn = CW'(n);
    @(negedge clk);
    start = 0;
    while (q.size() != 0 && !stopNext) begin
      check(busy && memReq && memAddr == AW'(q[0].addr) && memWe == q[0].we,
            q.size() > 2 * n ? "R2 priming access" : "R3 copy access",
            memAddr, q[0].addr);
      nmiV = 0; irqV = 0; mskV = 0;
      case (irqStyle)
        1: begin nmiV = ($urandom_range(0, 9) == 0); irqV = $urandom_range(0, 1);
                 mskV = $urandom_range(0, 1); end
        2: nmiV = 1;
        3: begin irqV = 1; mskV = 1; end
        default: ;
      endcase
      pend = nmiV | (irqV & ~mskV);
      if (q[0].we) begin
        check(memWdata == refMem[s + k], "R3 write data", memWdata, refMem[s + k]);
        refMem[d + k] = refMem[s + k];
        k++;
        if (!atomic && pend && k < n) stopNext = 1;
      end
      nmiReq = nmiV; irqReq = irqV; irqMask = mskV;
      // stray start while busy must be ignored (R10)
      start = (irqStyle == 1) && (q.size() > 1) && ($urandom_range(0, 7) == 0);
      srcIn = AW'($urandom_range(0, 500)); cntIn = CW'($urandom_range(0, 9));
      void'(q.pop_front());
      @(negedge clk);
      start = 0;
    end
    nmiReq = 0; irqReq = 0; irqMask = 0;
    wasSusp = stopNext;
    check(!busy, "R5 idle after run", busy, 0);
    check(done == !stopNext && suspended == stopNext,
          stopNext ? "R6 suspended flag" : (atomic ? "R8 done flag" : "R5 done flag"),
          {done, suspended}, {!stopNext, stopNext});
    check(srcPtr == AW'(s + k), "R5 R6 srcPtr", srcPtr, s + k);
    check(dstPtr == AW'(d + k), "R5 R6 dstPtr", dstPtr, d + k);
    check(count == CW'(n - k), "R5 R6 count", count, n - k);
    @(negedge clk);
    check(done == !stopNext && suspended == stopNext && !memReq, "R5 flags held",
          {done, suspended}, {!stopNext, stopNext});
  endtask

  task automatic runToEnd(input int s, input int d, input int n, input int irqStyle,
                          input int minSusp);
    bit sp = 1;
    int nSusp = 0;
    int cs = s, cd = d, cn = n;
    while (sp) begin
      runCopy(cs, cd, cn, 0, irqStyle, sp);
      if (sp) nSusp++;
      cs = srcPtr; cd = dstPtr; cn = count;
    end
    check(nSusp >= minSusp, "R11 R9 suspension count", nSusp, minSusp);
  endtask

  initial begin
    bit sp;
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = 8'($urandom);
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !suspended && !memReq, "R1 reset state",
          {busy, done, suspended, memReq}, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !memReq, "R1 idle after reset", {busy, memReq}, 0);

    runCopy(40, 60, 0, 0, 2, sp);          // R4 zero count, nmi ignored
    check(!sp && srcPtr == 40 && count == 0, "R4 zero count", srcPtr, 40);
    runCopy(100, 200, 5, 1, 0, sp);        // R2 R3 R5 atomic quiet
    runCopy(300, 320, 8, 1, 2, sp);        // R8 nmi held atomic
    check(!sp, "R8 no suspension", sp, 0);
    runCopy(400, 420, 6, 0, 3, sp);        // R7 masked irq held
    check(!sp, "R7 masked ignored", sp, 0);
    runCopy(500, 502, 10, 0, 0, sp);       // R3 overlapping forward copy
    runToEnd(600, 640, 4, 2, 3);           // R6 R9 R11 one byte per restart
    runToEnd(700, 760, 40, 1, 0);          // R10 R11 random requests
    runToEnd(150, 170, 30, 1, 0);
    runCopy(800, 900, 12, 1, 1, sp);       // R8 R10 random in atomic
    check(!sp, "R8 random atomic", sp, 0);

    repeat (2) @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < MEMN; i++) if (mem[i] !== refMem[i]) bad++;
      check(bad == 0, "R11 R3 final memory image", bad, 0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule